// File: doc/BRIEF.md
# Operator Console Mode Controller

This block is the control core of the operator console of a small stored-program computer. It takes three debounced pushbutton levels: select, action and enter. A select press moves the console through six modes: an idle position and five working modes. The active mode is shown as one lit LED. The action button then carries out the operation of the current mode. The operations are starting or stopping the processor, issuing a single instruction cycle, loading the program counter from the switches, depositing the switch word into memory, and examining memory.

The block drives single-cycle control strobes to the processor, a level that keeps the fetched instruction forced to a halt while the console is working on memory, and a register-select code for the display multiplexer. Holding enter forces the display onto the switch register in every mode. Two more LEDs show the processor's running state and its Q output. Every interface here is a plain control or status pin: presses are edge events and strobes are fire-and-forget pulses, so no valid/ready handshake and no back-pressure exists.

Top module: `fp_panel_ctrl`

## Requirements
- R1: After reset the mode is idle (0), the processor is stopped, and every strobe is low.
- R2: Each rising edge on `sel_btn` advances the mode by one, from 0 through 5, and 5 wraps to 0. Holding the button longer does not advance it again.
- R3: `led[5:0]` is one-hot with bit m lit for mode m. `led[6]` shows the running state and `led[7]` follows `cpu_q`.
- R4: In mode 5 (run/stop) an action press toggles the running state. A `cpu_halt` pulse clears the running state and wins over a toggle in the same cycle.
- R5: In mode 4 (step) an action press while stopped gives exactly one `step_pulse` cycle, in the cycle after the press edge. While running it gives none.
- R6: In mode 1 (load PC) an action press while stopped gives one `ldpc_pulse` cycle in the cycle after the press edge.
- R7: In mode 3 (deposit) an action press while stopped gives one `dep_pulse` cycle in the cycle after the press edge, followed in the next cycle by one `pcinc_pulse` cycle.
- R8: In mode 2 (examine) an action press while stopped gives one `exam_pulse` cycle, followed in the next cycle by one `pcinc_pulse` cycle.
- R9: In modes 1, 2 and 3, action presses made while running produce no strobe.
- R10: In mode 0 (idle) action and enter presses produce no strobe and leave the running state unchanged.
- R11: `disp_sel` is 3 (switch register) whenever `ent_btn` is high. Otherwise it is 0 (PC) in modes 1 and 3, 1 (IR) in mode 2, and 2 (AC) in modes 0, 4 and 5.
- R12: `ir_halt_force` is high exactly while the mode is 2 or 3.
- R13: A press held high for many cycles produces only one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_btn | input | 1 | Debounced select button level |
| act_btn | input | 1 | Debounced action button level |
| ent_btn | input | 1 | Debounced enter button level |
| cpu_q | input | 1 | Processor Q output, shown on LED 7 |
| cpu_halt | input | 1 | Pulse from the processor when it halts |
| led | output | 8 | Mode one-hot [5:0], running [6], Q [7] |
| run_level | output | 1 | Processor run enable |
| step_pulse | output | 1 | Single instruction cycle request |
| ldpc_pulse | output | 1 | Load PC from switches |
| dep_pulse | output | 1 | Write switch word to memory at PC |
| exam_pulse | output | 1 | Read memory at PC |
| pcinc_pulse | output | 1 | Increment PC after deposit or examine |
| ir_halt_force | output | 1 | Force fetched instruction to halt |
| disp_sel | output | 2 | Display register select |

## Verification
The hardest case to reach is a memory or step operation tried while the processor is running. The run toggle is only available in mode 5, and the mode ring only moves forward, so the stimulus starts the processor and then walks select through the wrap into modes 1 to 4, pressing action at each stop. A second hard case is a halt pulse that lands on the same edge as a run-toggle press; the stimulus lines the two up deliberately. A reference model in the bench is compared with every output on every clock.

// File: rtl/fp_panel_pkg.sv
package fp_panel_pkg;

  localparam int FP_NUM_MODES = 6;
  localparam int FP_MODE_W    = $clog2(FP_NUM_MODES);
  localparam int FP_LED_W     = FP_NUM_MODES + 2;
  localparam int FP_SEL_W     = 2;

  typedef enum logic [FP_MODE_W-1:0] {
    MODE_IDLE = 3'd0,
    MODE_LDPC = 3'd1,
    MODE_EXAM = 3'd2,
    MODE_DEP  = 3'd3,
    MODE_STEP = 3'd4,
    MODE_RUN  = 3'd5
  } fp_mode_e;

  typedef enum logic [FP_SEL_W-1:0] {
    DSEL_PC = 2'd0,
    DSEL_IR = 2'd1,
    DSEL_AC = 2'd2,
    DSEL_SW = 2'd3
  } fp_dsel_e;

  typedef struct packed {
    logic step;
    logic ldpc;
    logic dep;
    logic exam;
    logic pcinc;
  } fp_strobe_t;

endpackage

// File: rtl/fp_rise_detect.sv
module fp_rise_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  // one history flop per button
  for (genvar i = 0; i < N; i++) begin : g_btn
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q;
  end
endmodule

// File: rtl/fp_mode_ring.sv
module fp_mode_ring
  import fp_panel_pkg::*;
#(
  parameter int NUM_MODES = FP_NUM_MODES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  output logic [FP_MODE_W-1:0] mode
);
  localparam logic [FP_MODE_W-1:0] LAST = FP_MODE_W'(NUM_MODES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode <= '0;
    else if (adv)
      mode <= (mode == LAST) ? '0 : mode + 1'b1;
  end
endmodule

// File: rtl/fp_op_seq.sv
module fp_op_seq
  import fp_panel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FP_MODE_W-1:0] mode,
  input  logic                 act_rise,
  input  logic                 cpu_halt,
  output logic                 running,
  output fp_strobe_t           stb
);
  logic inc_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      stb      <= '0;
      inc_pend <= 1'b0;
    end else begin
      stb       <= '0;
      stb.pcinc <= inc_pend;
      inc_pend  <= 1'b0;
      if (act_rise) begin
        case (mode)
          MODE_RUN:  running <= ~running;
          MODE_STEP: stb.step <= ~running;
          MODE_LDPC: stb.ldpc <= ~running;
          MODE_DEP: begin
            stb.dep  <= ~running;
            inc_pend <= ~running;
          end
          MODE_EXAM: begin
            stb.exam <= ~running;
            inc_pend <= ~running;
          end
          default: ;
        endcase
      end
      // a halt from the processor wins over a start request
      if (cpu_halt) running <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_panel_ctrl.sv
module fp_panel_ctrl
  import fp_panel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_btn,
  input  logic                act_btn,
  input  logic                ent_btn,
  input  logic                cpu_q,
  input  logic                cpu_halt,
  output logic [FP_LED_W-1:0] led,
  output logic                run_level,
  output logic                step_pulse,
  output logic                ldpc_pulse,
  output logic                dep_pulse,
  output logic                exam_pulse,
  output logic                pcinc_pulse,
  output logic                ir_halt_force,
  output logic [FP_SEL_W-1:0] disp_sel
);
  localparam int NBTN = 2;

  logic [NBTN-1:0]      rise;
  logic [FP_MODE_W-1:0] mode;
  logic                 running;
  fp_strobe_t           stb;

  fp_rise_detect #(.N(NBTN)) u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({act_btn, sel_btn}),
    .rise (rise)
  );

  fp_mode_ring #(.NUM_MODES(FP_NUM_MODES)) u_ring (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (rise[0]),
    .mode (mode)
  );

  fp_op_seq u_ops (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .act_rise(rise[1]),
    .cpu_halt(cpu_halt),
    .running (running),
    .stb     (stb)
  );

  for (genvar m = 0; m < FP_NUM_MODES; m++) begin : g_led
    assign led[m] = (mode == FP_MODE_W'(m));
  end
  assign led[FP_NUM_MODES]     = running;
  assign led[FP_NUM_MODES + 1] = cpu_q;

  always_comb begin
    if (ent_btn)
      disp_sel = DSEL_SW;
    else begin
      case (mode)
        MODE_LDPC, MODE_DEP: disp_sel = DSEL_PC;
        MODE_EXAM:           disp_sel = DSEL_IR;
        default:             disp_sel = DSEL_AC;
      endcase
    end
  end

  assign ir_halt_force = (mode == MODE_DEP) || (mode == MODE_EXAM);
  assign run_level     = running;
  assign step_pulse    = stb.step;
  assign ldpc_pulse    = stb.ldpc;
  assign dep_pulse     = stb.dep;
  assign exam_pulse    = stb.exam;
  assign pcinc_pulse   = stb.pcinc;
endmodule

// File: rtl/fp_panel_ctrl_chk.sv
module fp_panel_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_btn,
  input logic       ent_btn,
  input logic       cpu_halt,
  input logic [7:0] led,
  input logic       run_level,
  input logic       step_pulse,
  input logic       ldpc_pulse,
  input logic       dep_pulse,
  input logic       exam_pulse,
  input logic       pcinc_pulse,
  input logic       ir_halt_force,
  input logic [1:0] disp_sel
);
  p_led_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(led[5:0]) == 1);

  p_select_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_btn) |=> led[5:0] != $past(led[5:0]));

  p_halt_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |=> !run_level);

  p_no_step_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> !run_level);

  p_step_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);

  p_dep_then_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dep_pulse |=> pcinc_pulse);

  p_exam_then_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exam_pulse |=> pcinc_pulse);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    led[0] |=> !(step_pulse || ldpc_pulse || dep_pulse || exam_pulse));

  p_enter_sw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ent_btn |-> disp_sel == 2'd3);

  p_halt_ir_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ir_halt_force == (led[2] || led[3]));
endmodule

bind fp_panel_ctrl fp_panel_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_btn      (sel_btn),
  .ent_btn      (ent_btn),
  .cpu_halt     (cpu_halt),
  .led          (led),
  .run_level    (run_level),
  .step_pulse   (step_pulse),
  .ldpc_pulse   (ldpc_pulse),
  .dep_pulse    (dep_pulse),
  .exam_pulse   (exam_pulse),
  .pcinc_pulse  (pcinc_pulse),
  .ir_halt_force(ir_halt_force),
  .disp_sel     (disp_sel)
);

// File: tb/fp_panel_ctrl_bench.sv
module fp_panel_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s = 1'b0, a = 1'b0, e = 1'b0, q = 1'b0, h = 1'b0;
  logic [7:0] led;
  logic run_level, step_pulse, ldpc_pulse, dep_pulse, exam_pulse, pcinc_pulse;
  logic ir_halt_force;
  logic [1:0] disp_sel;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_panel_ctrl u_fp_panel_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_btn(s), .act_btn(a), .ent_btn(e),
    .cpu_q(q), .cpu_halt(h), .led(led), .run_level(run_level),
    .step_pulse(step_pulse), .ldpc_pulse(ldpc_pulse), .dep_pulse(dep_pulse),
    .exam_pulse(exam_pulse), .pcinc_pulse(pcinc_pulse),
    .ir_halt_force(ir_halt_force), .disp_sel(disp_sel)
  );

  // behavioural reference model
  int m_mode = 0;
  bit m_run = 0, m_sp = 0, m_ps = 0, m_pa = 0;
  bit m_step = 0, m_ld = 0, m_dep = 0, m_exam = 0, m_inc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_sp = 0; m_pa = 0; m_ps = 0;
      m_step = 0; m_ld = 0; m_dep = 0; m_exam = 0; m_inc = 0;
    end else begin
      bit sr, ar;
      int old;
      sr = s && !m_sp;
      ar = a && !m_pa;
      old = m_mode;
      m_inc = m_ps; m_ps = 0;
      m_step = 0; m_ld = 0; m_dep = 0; m_exam = 0;
      if (sr) m_mode = (m_mode == 5) ? 0 : m_mode + 1;
      if (ar) begin
        if (old == 5) m_run = !m_run;
        else if (!m_run) begin
          if (old == 4) m_step = 1;
          if (old == 1) m_ld = 1;
          if (old == 3) begin m_dep = 1; m_ps = 1; end
          if (old == 2) begin m_exam = 1; m_ps = 1; end
        end
      end
      if (h) m_run = 0;
      m_sp = s; m_pa = a;
    end
  end

  task automatic chk1(string req, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] el;
    int ed;
    el = {q, m_run, 6'b0};
    el[m_mode] = 1'b1;
    ed = e ? 3 : (m_mode == 1 || m_mode == 3) ? 0 : (m_mode == 2) ? 1 : 2;
    vectors++;
    chk1("R3", "led", led, el);
    chk1("R4", "run_level", run_level, m_run);
    chk1("R5", "step_pulse", step_pulse, m_step);
    chk1("R6", "ldpc_pulse", ldpc_pulse, m_ld);
    chk1("R7", "dep_pulse", dep_pulse, m_dep);
    chk1("R7", "pcinc_pulse", pcinc_pulse, m_inc);
    chk1("R8", "exam_pulse", exam_pulse, m_exam);
    chk1("R11", "disp_sel", disp_sel, ed);
    chk1("R12", "ir_halt_force", ir_halt_force, (m_mode == 2 || m_mode == 3));
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      compare();
    end
  endtask

  task automatic press_sel(int hold = 1);
    s = 1; cyc(hold); s = 0; cyc(2);
  endtask

  task automatic press_act(int hold = 1);
    a = 1; cyc(hold); a = 0; cyc(2);
  endtask

  task automatic goto_mode(int m);
    while (m_mode != m) press_sel();
  endtask

  initial begin
    cyc(3);
    // R1: reset state
    chk1("R1", "led after reset", led, 8'h01);
    chk1("R1", "strobes after reset",
         {run_level, step_pulse, ldpc_pulse, dep_pulse, exam_pulse, pcinc_pulse}, 0);
    rst_n = 1;
    cyc(2);
    // R2 / R13: walk the ring past the wrap, with long holds
    for (int i = 0; i < 7; i++) press_sel((i % 3) + 1);
    press_sel(9);
    // R10: idle mode ignores action and enter
    goto_mode(0);
    press_act(3);
    e = 1; cyc(4); e = 0; cyc(2);
    // R6 load PC, R8 examine, R7 deposit while stopped
    goto_mode(1); press_act();
    goto_mode(2); press_act(); press_act(5);
    goto_mode(3); press_act(); e = 1; press_act(); e = 0; cyc(1);
    // R5 step while stopped, held long for R13
    goto_mode(4); press_act(); press_act(12);
    // R4 start running, enter held for R11, Q for R3
    goto_mode(5); q = 1; press_act(); e = 1; cyc(3); e = 0; q = 0; cyc(1);
    // R9 / R5: walk through all modes while running, pressing action
    for (int i = 0; i < 5; i++) begin press_sel(); press_act(2); end
    goto_mode(5);
    chk1("R4", "still running", run_level, 1);
    press_act();
    chk1("R4", "stopped by toggle", run_level, 0);
    // R4: halt pulse while running, then halt coinciding with a start press
    press_act(); h = 1; cyc(1); h = 0; cyc(2);
    chk1("R4", "halt clears run", run_level, 0);
    a = 1; h = 1; cyc(1); h = 0; cyc(1); a = 0; cyc(2);
    chk1("R4", "halt wins over start", run_level, 0);
    // back-to-back deposits
    goto_mode(3); press_act(); press_act(); press_act();
    // reset mid-run returns to idle (R1)
    goto_mode(5); press_act(); rst_n = 0; cyc(2); rst_n = 1; cyc(1);
    chk1("R1", "led after second reset", led, 8'h01);
    cyc(4);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule